// File: doc/BRIEF.md
# Two-Identifier I2C Slave with User Memory

This block is a serial bus slave that sits behind one clock/data pin pair and answers two distinct 7-bit device identifiers. Identifier `1010111` opens a 128-byte user memory held inside the block. Identifier `1101111` opens a control register space whose contents live outside the block: writes to that space appear as single-cycle strobes on a parallel port, and read data is taken from a parallel input.

Both pins are sampled on a fast system clock that runs at least eight times the bus clock rate. The block detects START and STOP conditions and frames each byte. It takes a device byte, then a word address, then data, and pulls the data line low during the ninth clock to acknowledge. For reads, the block shifts bytes out through an open-drain enable. It lets go of the line in the ninth clock so the master can answer.

A shared word pointer auto-increments after every byte in either direction. This supports multi-byte bursts, and reads that resume where the last access stopped. For a short window after reset the block ignores the bus entirely.

Top module: `i2c_dual_slave`

## Requirements
- R1: For 16 system clocks after reset, the block ignores START conditions and keeps `sda_oe` low. A device byte that follows a START during this window is not acknowledged.
- R2: The block responds only after a START, meaning SDA falls while SCL is high. A STOP, meaning SDA rises while SCL is high, returns it to idle. A repeated START restarts device-byte parsing.
- R3: A device byte whose upper seven bits are `1010111` (user memory) or `1101111` (control space) is acknowledged by driving SDA low for the ninth clock. Any other value gets no acknowledge, and later bytes are ignored until the next START.
- R4: Every byte is shifted most significant bit first, both into and out of the block.
- R5: A write is a device byte with bit 0 = 0, then a word address byte, then data bytes. Each of these bytes is acknowledged, and each data byte is stored in user memory at the current pointer.
- R6: In user memory the word address is masked to its low 7 bits. The pointer advances after each byte and wraps from 7Fh to 00h.
- R7: In a read (device byte bit 0 = 1), the block drives each data byte and releases SDA for the ninth clock. A master acknowledge (SDA low) fetches the byte at the next address. A master non-acknowledge ends the transfer, and SDA stays released.
- R8: Control-space accesses do not touch user memory. Each written byte pulses `ctl_we` for one cycle, with `ctl_addr` and `ctl_wdata` valid in that cycle. Read bytes are taken from `ctl_rdata` for the address shown on `ctl_addr`.
- R9: A read that is not preceded by a word address starts at the address after the last byte written or read.
- R10: `sda_oe` is only asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level |
| sda_oe | output | 1 | When high, the data pin is pulled low |
| ctl_addr | output | 8 | Control-space word address (current pointer) |
| ctl_wdata | output | 8 | Control-space write data |
| ctl_we | output | 1 | One-cycle control-space write strobe |
| ctl_rdata | input | 8 | Control-space read data for `ctl_addr` |

## Verification
Several rules are checked by assertions on every cycle. The data-line enable stays low through the power-up window and whenever the slave is idle. It only rises while the synchronized clock is low. A control write is followed by an acknowledge. The user-space pointer never leaves the 128-byte range. The bench's scenarios are needed for behaviour that spans whole transactions. That covers the bit order and the contents of stored bytes, the 7Fh-to-00h wrap, and a burst read ending on a master non-acknowledge. It also covers resuming from the last address, repeated-START restarts, and rejection of unknown identifiers.

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave #(
  parameter logic [6:0] USER_ID   = 7'h57,
  parameter logic [6:0] CTRL_ID   = 7'h6F,
  parameter int         MEM_DEPTH = 128,
  parameter int         HOLDOFF   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] ctl_addr,
  output logic [7:0] ctl_wdata,
  output logic       ctl_we,
  input  logic [7:0] ctl_rdata
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int HW = $clog2(HOLDOFF + 1);
  localparam logic [7:0] UMASK = 8'(MEM_DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_ID, S_ADDR, S_WR, S_RD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_s, sda_s, scl_q, sda_q;
  logic       scl_rise, scl_fall, start_c, stop_c;
  logic [HW-1:0] hold_cnt;
  logic       ready;
  st_t        state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr, rd_byte;
  logic       user_sel, nack, hit_user, hit_ctrl, mem_we, wr_slot, idle_st;
  logic [7:0] mem [MEM_DEPTH];

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign ready    = (hold_cnt == HW'(HOLDOFF));
  assign idle_st  = (state == S_IDLE);

  assign hit_user = (shreg[7:1] == USER_ID);
  assign hit_ctrl = (shreg[7:1] == CTRL_ID);
  assign rd_byte  = user_sel ? mem[ptr[AW-1:0]] : ctl_rdata;
  assign wr_slot  = (state == S_WR) && scl_fall && (bitcnt == 4'd8);
  assign mem_we   = wr_slot && user_sel;
  assign ctl_we   = wr_slot && !user_sel;
  assign ctl_wdata = shreg;
  assign ctl_addr  = ptr;

  function automatic logic [7:0] nxt(input logic [7:0] p, input logic u);
    logic [7:0] n;
    n = p + 8'd1;
    return u ? (n & UMASK) : n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_cnt <= '0;
    else if (!ready) hold_cnt <= hold_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr[AW-1:0]] <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      user_sel <= 1'b0;
      nack     <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_c && ready) begin
      state  <= S_ID;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ID, S_ADDR, S_WR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (state == S_ID) begin
              if (hit_user || hit_ctrl) begin
                sda_oe   <= 1'b1;
                user_sel <= hit_user;
                if (hit_user) ptr <= ptr & UMASK;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_ADDR) begin
              sda_oe <= 1'b1;
              ptr    <= user_sel ? (shreg & UMASK) : shreg;
            end else begin
              sda_oe <= 1'b1;
              ptr    <= nxt(ptr, user_sel);
            end
          end else if (scl_fall && bitcnt == 4'd9) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            if (state == S_ID) begin
              if (shreg[0]) begin
                state  <= S_RD;
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else begin
                state <= S_ADDR;
              end
            end else if (state == S_ADDR) begin
              state <= S_WR;
            end
          end
        end
        S_RD: begin
          if (scl_fall && bitcnt < 4'd7) begin
            bitcnt <= bitcnt + 4'd1;
            shreg  <= {shreg[6:0], 1'b0};
            sda_oe <= ~shreg[6];
          end else if (scl_fall && bitcnt == 4'd7) begin
            bitcnt <= 4'd8;
            sda_oe <= 1'b0;
            ptr    <= nxt(ptr, user_sel);
          end else if (scl_rise && bitcnt == 4'd8) begin
            nack   <= sda_s;
            bitcnt <= 4'd9;
          end else if (scl_fall && bitcnt == 4'd9) begin
            if (nack) begin
              state <= S_IDLE;
            end else begin
              bitcnt <= '0;
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_dual_slave_chk.sv
module i2c_dual_slave_chk #(
  parameter int HOLDOFF   = 16,
  parameter int MEM_DEPTH = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       ctl_we,
  input logic       user_sel,
  input logic       idle_st,
  input logic [7:0] ptr
);
  logic [31:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since <= '0;
    else if (since < 32'(HOLDOFF))  since <= since + 32'd1;
  end

  assert_holdoff_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since < 32'(HOLDOFF)) |-> !sda_oe)
    else $error("sda_oe asserted in power-up window");

  assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_st |-> !sda_oe)
    else $error("sda_oe asserted while idle");

  assert_ctl_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> sda_oe)
    else $error("control write not acknowledged");

  assert_user_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_st && user_sel) |-> (32'(ptr) < 32'(MEM_DEPTH)))
    else $error("user pointer out of range");

  assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s)
    else $error("sda_oe rose while SCL high");
endmodule

bind i2c_dual_slave i2c_dual_slave_chk #(.HOLDOFF(HOLDOFF), .MEM_DEPTH(MEM_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .ctl_we(ctl_we),
  .user_sel(user_sel), .idle_st(idle_st), .ptr(ptr)
);

// File: tb/tb_i2c_dual_slave.sv
`timescale 1ns/1ps
module tb_i2c_dual_slave;
  localparam int Q = 10;
  localparam logic [7:0] UW = 8'hAE, UR = 8'hAF, CW = 8'hDE, CR = 8'hDF;
  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h7F3C, 16'h855A, 16'h4081, 16'h12FF, 16'h0001};

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, done = 0;
  logic sda_oe, ctl_we;
  logic [7:0] ctl_addr, ctl_wdata, ctl_rdata;
  wire sda_line = sda_m & ~sda_oe;
  int nchk = 0, nerr = 0, wr_cnt = 0, oe_bad = 0;
  logic [7:0] last_wa, last_wd;
  logic prev_oe = 0;

  always #2.5 clk = ~clk;
  assign ctl_rdata = ctl_addr ^ 8'hC3;

  i2c_dual_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata));

  always @(posedge clk) begin
    if (ctl_we) begin wr_cnt <= wr_cnt + 1; last_wa <= ctl_addr; last_wd <= ctl_wdata; end
    if (sda_oe && !prev_oe && scl_m) oe_bad <= oe_bad + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; waitq(); scl_m = 1; waitq(); sda_m = 0; waitq(); scl_m = 0; waitq(); endtask
  task automatic i2c_stop(); sda_m = 0; waitq(); scl_m = 1; waitq(); sda_m = 1; waitq(); endtask
  task automatic wbit(input logic b); sda_m = b; waitq(); scl_m = 1; waitq(); waitq(); scl_m = 0; waitq(); endtask
  task automatic rbit(output logic b); sda_m = 1; waitq(); scl_m = 1; waitq(); b = sda_line; waitq(); scl_m = 0; waitq(); endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack);
  endtask

  task automatic rbyte(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(last);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    i2c_start(); wbyte(UW, acks[2]); wbyte(a, acks[1]); wbyte(d, acks[0]); i2c_stop();
  endtask

  task automatic rd_at(input logic [7:0] a, output logic [7:0] d);
    logic ak;
    i2c_start(); wbyte(UW, ak); wbyte(a, ak); i2c_start(); wbyte(UR, ak); rbyte(1'b1, d); i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [2:0] acks;
    logic [7:0] d;
    int wc0;
    repeat (5) @(negedge clk);
    chk("R1 reset sda_oe", sda_oe, 0);
    rst_n = 1;
    // R1: START inside the power-up window is ignored
    repeat (3) @(negedge clk);
    sda_m = 0;
    repeat (3) @(negedge clk);
    scl_m = 0;
    waitq();
    wbyte(UW, ak);
    chk("R1 start during hold-off ignored", ak, 1);
    i2c_stop();

    // R5/R6/R4: vector table of write then random read
    foreach (VEC[k]) begin
      wr1(VEC[k][15:8], VEC[k][7:0], acks);
      chk("R5 write acks", acks, 3'b000);
      rd_at(VEC[k][15:8] & 8'h7F, d);
      chk("R4 R6 readback", d, VEC[k][7:0]);
    end

    // R3: unknown identifier
    i2c_start(); wbyte(8'hA0, ak);
    chk("R3 unknown id no ack", ak, 1);
    wbyte(8'h55, ak);
    chk("R3 later byte ignored", ak, 1);
    i2c_stop();

    // R2: no response without START
    wbyte(UW, ak);
    chk("R2 no start no ack", ak, 1);
    i2c_stop();

    // R6: wrap from 7F to 00 during a burst write
    i2c_start(); wbyte(UW, ak); wbyte(8'h7F, ak); wbyte(8'h11, ak); wbyte(8'h22, ak);
    chk("R6 burst ack", ak, 0);
    i2c_stop();
    rd_at(8'h00, d); chk("R6 wrap write 00", d, 8'h22);
    rd_at(8'h7F, d); chk("R6 write 7F", d, 8'h11);

    wr1(8'h01, 8'h4D, acks);
    wr1(8'h7E, 8'h6B, acks);

    // R7: sequential read across wrap, ending with NACK
    i2c_start(); wbyte(UW, ak); wbyte(8'h7E, ak); i2c_start(); wbyte(UR, ak);
    chk("R3 user read id ack", ak, 0);
    rbyte(1'b0, d); chk("R7 seq byte0", d, 8'h6B);
    rbyte(1'b0, d); chk("R7 seq byte1", d, 8'h11);
    rbyte(1'b1, d); chk("R7 seq byte2 wrapped", d, 8'h22);
    repeat (8) @(negedge clk);
    chk("R7 released after nack", sda_oe, 0);
    i2c_stop();

    // R9: current-address read resumes after last byte read (00 -> 01)
    i2c_start(); wbyte(UR, ak); rbyte(1'b1, d); i2c_stop();
    chk("R9 current address read", d, 8'h4D);

    // R2: repeated START restarts parsing for a write
    i2c_start(); wbyte(UW, ak); wbyte(8'h30, ak); i2c_start(); wbyte(UW, ak); wbyte(8'h31, ak); wbyte(8'h5E, ak);
    i2c_stop();
    rd_at(8'h31, d); chk("R2 repeated start write", d, 8'h5E);

    // R8: control-space write
    wc0 = wr_cnt;
    i2c_start(); wbyte(CW, ak);
    chk("R3 control id ack", ak, 0);
    wbyte(8'h22, ak); wbyte(8'h1E, ak);
    chk("R8 control data ack", ak, 0);
    i2c_stop();
    chk("R8 one write strobe", wr_cnt, wc0 + 1);
    chk("R8 write address", last_wa, 8'h22);
    chk("R4 R8 write data msb first", last_wd, 8'h1E);

    // R8: control write to 05 leaves user memory 05 alone
    i2c_start(); wbyte(CW, ak); wbyte(8'h05, ak); wbyte(8'h00, ak); i2c_stop();
    rd_at(8'h05, d); chk("R8 user memory untouched", d, 8'h5A);

    // R8: control-space burst read
    i2c_start(); wbyte(CW, ak); wbyte(8'h30, ak); i2c_start(); wbyte(CR, ak);
    rbyte(1'b0, d); chk("R8 control read 30", d, 8'hF3);
    rbyte(1'b1, d); chk("R8 control read 31", d, 8'hF2);
    i2c_stop();

    chk("R10 oe rises only with scl low", oe_bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule